// File: doc/BRIEF.md
# Flag-Producing Combinational ALU

This block is the arithmetic and logic stage of a small 16-bit processor. It takes two operand buses and a 4-bit operation code. In the same cycle it returns a 16-bit result and a 4-bit flag vector. The processor's control sequence latches that flag vector into its condition register.

There are eight operations:

- Add, subtract, AND, OR and XOR use both operand buses.
- Shift and rotate are single-operand operations. They move only `srcA`, by one bit, and bit 0 of `srcB` picks the direction.
- Move passes `srcA` straight through. The move instruction therefore still produces valid zero and sign flags.

The block has no clock, no state and no control input other than the operation code.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 (add) drives `result` = (`srcA` + `srcB`) mod 2^16. It sets the carry flag to the carry out of bit 15.
- R2: Operation code 1 (subtract) drives `result` = (`srcA` - `srcB`) mod 2^16. It sets the carry flag to 1 exactly when `srcA` < `srcB` as unsigned numbers, which marks a borrow.
- R3: For add and subtract only, the overflow flag is 1 exactly when the two's-complement result falls outside -32768..32767.
- R4: Operation codes 2, 3 and 4 drive the bitwise AND, OR and XOR of `srcA` and `srcB`. For these the carry and overflow flags are 0.
- R5: Operation code 5 (shift) moves `srcA` one bit and fills the vacated end with 0. `srcB` bit 0 = 0 shifts left and 1 shifts right. Bits 15..1 of `srcB` have no effect. Carry and overflow are 0.
- R6: Operation code 6 (rotate) moves `srcA` one bit and feeds the bit that leaves back in at the other end. The direction is taken from `srcB` bit 0 as in R5. Carry and overflow are 0.
- R7: Operation code 7 (move) drives `result` = `srcA` for any value of `srcB`. Carry and overflow are 0.
- R8: For every operation code, `flags` bit 0 (zero) is 1 exactly when `result` is 0, and `flags` bit 1 (sign) equals `result` bit 15. `flags` bit 2 is carry and bit 3 is overflow.
- R9: Operation codes 8 to 15 drive `result` = 0. They drive `flags` = 4'b0001, with only the zero flag set.
- R10: The outputs settle from the inputs alone. A change on any input shows up on `result` and `flags` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcA | input | 16 | First operand; the only operand moved by shift, rotate and move |
| srcB | input | 16 | Second operand; bit 0 is the direction for shift and rotate |
| opSel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift, 6 rotate, 7 move) |
| result | output | 16 | Operation result |
| flags | output | 4 | {overflow, carry, sign, zero} |

## Verification
The adder paths are driven with operand pairs chosen to set one outcome at a time:

- an unsigned carry with no signed overflow;
- a signed overflow with no carry;
- a borrow;
- a zero result.

A defect that confuses carry with overflow, or that inverts the borrow, therefore shows up in one specific case. Shift and rotate run in both directions on operands with both end bits set. This separates zero fill from wraparound and left from right. A `srcB` value whose upper bits are all ones shows that only bit 0 is read. Move, the unused codes and a seeded random sweep against a model written from the requirements cover the flag rules for every code.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_AND    = 4'd2,
    OP_OR     = 4'd3,
    OP_XOR    = 4'd4,
    OP_SHIFT  = 4'd5,
    OP_ROTATE = 4'd6,
    OP_MOVE   = 4'd7
  } aluOp_e;

  // One strobe per operation; all low for an unused code.
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic doShift;
    logic doRotate;
    logic doMove;
  } aluStrobe_t;

  typedef struct packed {
    logic ovf;
    logic carry;
    logic sign;
    logic zero;
  } aluFlags_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic [OP_W-1:0] opIn,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    case (opIn)
      OP_ADD:    strobe.doAdd    = 1'b1;
      OP_SUB:    strobe.doSub    = 1'b1;
      OP_AND:    strobe.doAnd    = 1'b1;
      OP_OR:     strobe.doOr     = 1'b1;
      OP_XOR:    strobe.doXor    = 1'b1;
      OP_SHIFT:  strobe.doShift  = 1'b1;
      OP_ROTATE: strobe.doRotate = 1'b1;
      OP_MOVE:   strobe.doMove   = 1'b1;
      default:   strobe          = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_datapath.sv
module alu_flag_datapath
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic              isArith;
  logic [DATA_W-1:0] bOperand;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] sumRes;
  logic              carryRaw;
  logic              ovfRaw;
  logic              dirRight;
  logic [DATA_W-1:0] shiftRes;
  logic [DATA_W-1:0] rotRes;

  // Shared adder: subtract is add of inverted srcB with carry-in.
  assign isArith  = strobe.doAdd | strobe.doSub;
  assign bOperand = srcB ^ {DATA_W{strobe.doSub}};
  assign sumFull  = {1'b0, srcA} + {1'b0, bOperand} + {{DATA_W{1'b0}}, strobe.doSub};
  assign sumRes   = sumFull[MSB:0];
  assign carryRaw = strobe.doSub ? ~sumFull[DATA_W] : sumFull[DATA_W];
  assign ovfRaw   = (srcA[MSB] == bOperand[MSB]) && (sumRes[MSB] != srcA[MSB]);

  // One-bit movers, direction from srcB bit 0.
  assign dirRight = srcB[0];
  assign shiftRes = dirRight ? {1'b0, srcA[MSB:1]} : {srcA[MSB-1:0], 1'b0};
  assign rotRes   = dirRight ? {srcA[0], srcA[MSB:1]} : {srcA[MSB-1:0], srcA[MSB]};

  // AND-OR result select over one-hot strobes.
  assign result = ({DATA_W{isArith}}         & sumRes)
                | ({DATA_W{strobe.doAnd}}    & (srcA & srcB))
                | ({DATA_W{strobe.doOr}}     & (srcA | srcB))
                | ({DATA_W{strobe.doXor}}    & (srcA ^ srcB))
                | ({DATA_W{strobe.doShift}}  & shiftRes)
                | ({DATA_W{strobe.doRotate}} & rotRes)
                | ({DATA_W{strobe.doMove}}   & srcA);

  assign flagsOut.zero  = (result == '0);
  assign flagsOut.sign  = result[MSB];
  assign flagsOut.carry = isArith & carryRaw;
  assign flagsOut.ovf   = isArith & ovfRaw;

  always_comb begin
    if (strobe.doAdd) begin
      // R1
      add_carry_chk: assert ({flagsOut.carry, result} == ({1'b0, srcA} + {1'b0, srcB}))
        else $error("add sum/carry mismatch");
    end
    if (strobe.doSub) begin
      // R2
      sub_inverse_chk: assert ((result + srcB) == srcA)
        else $error("subtract result does not invert");
      // R2
      sub_borrow_chk: assert (flagsOut.carry == (srcA < srcB))
        else $error("borrow flag wrong");
    end
    if (strobe.doAnd) begin
      // R4
      and_subset_chk: assert (((result & ~srcA) == '0) && ((result & ~srcB) == '0))
        else $error("and result has bits outside operands");
    end
    if (strobe.doShift && !srcB[0]) begin
      // R5
      shl_fill_chk: assert (result[0] == 1'b0)
        else $error("left shift did not fill with zero");
    end
    if (strobe.doRotate) begin
      // R6
      rot_count_chk: assert ($countones(result) == $countones(srcA))
        else $error("rotate lost or gained bits");
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [OP_W-1:0]   opSel,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  aluStrobe_t strobe;
  aluFlags_t  flagsS;

  alu_flag_ctrl u_ctrl (
    .opIn   (opSel),
    .strobe (strobe)
  );

  alu_flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .srcA     (srcA),
    .srcB     (srcB),
    .strobe   (strobe),
    .result   (result),
    .flagsOut (flagsS)
  );

  assign flags = flagsS;

  always_comb begin
    if (opSel >= OP_W'(8)) begin
      // R9
      unused_zero_chk: assert ((result == '0) && (flags == 4'b0001))
        else $error("unused code produced nonzero output");
    end
    if (opSel == OP_MOVE) begin
      // R7
      move_pass_chk: assert ((result == srcA) && (flags[3:2] == 2'b00))
        else $error("move did not pass srcA");
    end
  end

endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

  logic        clk = 1'b0;
  logic [15:0] srcA, srcB;
  logic [3:0]  opSel;
  logic [15:0] result;
  logic [3:0]  flags;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_flag_unit dut (
    .srcA(srcA), .srcB(srcB), .opSel(opSel),
    .result(result), .flags(flags)
  );

  // Independent model written from the requirements.
  function automatic logic [19:0] model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r;
    logic c, v;
    int sa, sb, sr;
    c = 1'b0; v = 1'b0;
    sa = $signed(a); sb = $signed(b);
    case (op)
      4'd0: begin
        r = a + b;
        c = (int'(a) + int'(b)) > 65535;
        sr = sa + sb;
        v = (sr > 32767) || (sr < -32768);
      end
      4'd1: begin
        r = a - b;
        c = a < b;
        sr = sa - sb;
        v = (sr > 32767) || (sr < -32768);
      end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = b[0] ? (a >> 1) : (a << 1);
      4'd6: r = b[0] ? ((a >> 1) | (a << 15)) : ((a << 1) | (a >> 15));
      4'd7: r = a;
      default: r = 16'h0;
    endcase
    return {r, v, c, r[15], (r == 16'h0)};
  endfunction

  task automatic applyCheck(input string tag, input logic [3:0] op, input logic [15:0] a,
                            input logic [15:0] b, input logic [15:0] expR, input logic [3:0] expF);
    @(negedge clk);
    opSel = op; srcA = a; srcB = b;
    #1;
    checks++;
    if (result !== expR || flags !== expF) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h actual result=%h flags=%b expected result=%h flags=%b",
               tag, op, a, b, result, flags, expR, expF);
    end
  endtask

  task automatic testIdle();
    applyCheck("R8 idle zero add", 4'd0, 16'h0000, 16'h0000, 16'h0000, 4'b0001);
  endtask

  task automatic testAdd();
    applyCheck("R1 add plain",      4'd0, 16'h1234, 16'h1111, 16'h2345, 4'b0000);
    applyCheck("R1 add carry",      4'd0, 16'hFFFF, 16'h0001, 16'h0000, 4'b0101);
    applyCheck("R3 add overflow",   4'd0, 16'h7FFF, 16'h0001, 16'h8000, 4'b1010);
    applyCheck("R3 add neg ovf",    4'd0, 16'h8000, 16'h8000, 16'h0000, 4'b1101);
  endtask

  task automatic testSub();
    applyCheck("R2 sub borrow",     4'd1, 16'h0005, 16'h0007, 16'hFFFE, 4'b0110);
    applyCheck("R3 sub overflow",   4'd1, 16'h8000, 16'h0001, 16'h7FFF, 4'b1000);
    applyCheck("R2 sub equal",      4'd1, 16'h4444, 16'h4444, 16'h0000, 4'b0001);
  endtask

  task automatic testLogic();
    applyCheck("R4 and",            4'd2, 16'hF0F0, 16'hFF00, 16'hF000, 4'b0010);
    applyCheck("R4 or",             4'd3, 16'h00F0, 16'h0F00, 16'h0FF0, 4'b0000);
    applyCheck("R4 xor zero",       4'd4, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b0001);
    applyCheck("R4 and all ones",   4'd2, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'b0010);
  endtask

  task automatic testShift();
    applyCheck("R5 shift left",     4'd5, 16'h8001, 16'h0000, 16'h0002, 4'b0000);
    applyCheck("R5 shift right",    4'd5, 16'h8001, 16'h0001, 16'h4000, 4'b0000);
    applyCheck("R5 upper b ignored",4'd5, 16'h4001, 16'hFFFE, 16'h8002, 4'b0010);
    applyCheck("R5 shift out zero", 4'd5, 16'h0001, 16'hFFFF, 16'h0000, 4'b0001);
  endtask

  task automatic testRotate();
    applyCheck("R6 rotate left",    4'd6, 16'h8001, 16'h0000, 16'h0003, 4'b0000);
    applyCheck("R6 rotate right",   4'd6, 16'h8001, 16'h0001, 16'hC000, 4'b0010);
    applyCheck("R6 upper b ignored",4'd6, 16'h0001, 16'hFFFF, 16'h8000, 4'b0010);
  endtask

  task automatic testMove();
    applyCheck("R7 move negative",  4'd7, 16'h8000, 16'h1234, 16'h8000, 4'b0010);
    applyCheck("R7 move zero",      4'd7, 16'h0000, 16'hFFFF, 16'h0000, 4'b0001);
  endtask

  task automatic testUnused();
    applyCheck("R9 code 8",         4'd8,  16'hFFFF, 16'hFFFF, 16'h0000, 4'b0001);
    applyCheck("R9 code 15",        4'd15, 16'h7FFF, 16'h0001, 16'h0000, 4'b0001);
  endtask

  // R10: inputs change twice between clock edges; outputs must follow each.
  task automatic testNoClock();
    @(posedge clk);
    #0.5;
    opSel = 4'd0; srcA = 16'h0010; srcB = 16'h0020;
    #0.5;
    checks++;
    if (result !== 16'h0030) begin
      errors++;
      $display("FAIL R10 first change: actual %h expected %h", result, 16'h0030);
    end
    srcB = 16'h0001;
    #0.5;
    checks++;
    if (result !== 16'h0011) begin
      errors++;
      $display("FAIL R10 second change: actual %h expected %h", result, 16'h0011);
    end
  endtask

  // R8 and all codes: seeded sweep against the model.
  task automatic testSweep();
    logic [19:0] e;
    logic [15:0] a, b;
    logic [3:0]  op;
    for (int i = 0; i < 400; i++) begin
      a  = 16'($urandom);
      b  = 16'($urandom);
      op = 4'(i % 16);
      e  = model(op, a, b);
      applyCheck("R8 sweep", op, a, b, e[19:4], e[3:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    srcA = '0; srcB = '0; opSel = '0;
    repeat (2) @(posedge clk);
    testIdle();
    testAdd();
    testSub();
    testLogic();
    testShift();
    testRotate();
    testMove();
    testUnused();
    testNoClock();
    testSweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule